// File: doc/BRIEF.md
# Host-to-Port I/O Window Translator

This block sits between a processor-side memory-mapped bus and a narrow I/O port bus. The processor reaches I/O ports by reading and writing inside a fixed 8 MB window of its address space. The block decides whether each host access lands in that window. For a hit it builds a 16-bit port address from the window offset and issues one port cycle. The access size, the write flag and the write data go to the port side unchanged.

Two folding schemes are available, chosen by a mode input from the control register block. In contiguous mode the low 16 offset bits are used directly, so the ports occupy one dense 64 KB run at the bottom of the window. In sparse mode each 4 KB page of the window carries 32 bytes of port space. The page number is placed just above the 5-bit byte offset, and the bits between them are dropped.

The host side takes one access at a time and answers with a single-cycle response. For a hit, that response comes only after the port side has accepted the request, and it carries the read data. For a miss, the block answers at once with a miss flag and no port cycle takes place.

Top module: `io_window_bridge`

## Requirements
- R1: A host address from 0x80000000 to 0x807FFFFF, inclusive, is a window hit and leads to exactly one port request. The offset is the host address minus 0x80000000.
- R2: With mapSparse=0, portAddr equals the window offset taken modulo 65536.
- R3: With mapSparse=1, portAddr equals (offset[22:12] << 5) | offset[4:0]. Offset bits [11:5] have no effect on portAddr.
- R4: For a hit, portSize, portWrite and portWdata equal the hostSize, hostWrite and hostWdata of the accepted access. The size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.
- R5: A host address outside the window never raises portValid. In the cycle after acceptance, hostRespValid is high for one cycle with hostMiss=1 and hostRdata=0.
- R6: mapSparse is sampled in the cycle the host access is accepted. Changing mapSparse while the port request is pending leaves portAddr unchanged.
- R7: The port request holds portValid and all of its fields stable until portReady is seen. hostRespValid then pulses for one cycle in the following cycle, with hostMiss=0 and hostRdata equal to the portRdata presented with portReady.
- R8: Coming out of reset, hostReady=1, portValid=0 and hostRespValid=0. hostReady is low from the cycle after acceptance until the response cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mapSparse | input | 1 | Folding mode: 0 contiguous, 1 sparse |
| hostValid | input | 1 | Host access request |
| hostReady | output | 1 | Block idle; an access is accepted when hostValid is also high |
| hostAddr | input | 32 | Host byte address |
| hostWrite | input | 1 | 1 for a write, 0 for a read |
| hostSize | input | 2 | Access size code (0: 1 B, 1: 2 B, 2: 4 B) |
| hostWdata | input | 32 | Host write data |
| hostRespValid | output | 1 | One-cycle completion pulse |
| hostMiss | output | 1 | Set with the response when the address was outside the window |
| hostRdata | output | 32 | Read data returned with the response |
| portValid | output | 1 | Port request pending |
| portReady | input | 1 | Port side accepts and completes the request |
| portAddr | output | 16 | Translated port address |
| portWrite | output | 1 | Forwarded write flag |
| portSize | output | 2 | Forwarded size code |
| portWdata | output | 32 | Forwarded write data |
| portRdata | input | 32 | Port read data, valid with portReady |

## Verification
The sparse mapping is driven with all 2048 page numbers. Each page carries varying values in the dropped middle bits, so the sweep separates a correct pack of page and byte offset from a shifted pack or one that leaks the middle bits. The contiguous mapping is driven with a thousand offsets whose upper bits vary, which shows whether the fold keeps exactly 16 bits. The window edges and the addresses just outside them distinguish an exact range decode from an off-by-one decode.

Other accesses change the mode while a port request is pending, and apply different port-ready delays with each size code. These show whether the mode is sampled at acceptance and whether the handshake and response timing hold.

// File: rtl/io_window_pkg.sv
package io_window_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PORT = 2'd1,
    ST_RESP = 2'd2
  } xferState_e;

  typedef struct packed {
    logic captureReq;
    logic captureRdata;
  } dpStrobe_t;

endpackage

// File: rtl/io_window_ctrl.sv
module io_window_ctrl
  import io_window_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostValid,
  input  logic       winHit,
  input  logic       portReady,
  output logic       hostReady,
  output logic       portValid,
  output logic       hostRespValid,
  output dpStrobe_t  strobe
);

  xferState_e stateQ, stateD;

  always_comb begin
    stateD        = stateQ;
    hostReady     = 1'b0;
    portValid     = 1'b0;
    hostRespValid = 1'b0;
    strobe        = '0;
    case (stateQ)
      ST_IDLE: begin
        hostReady = 1'b1;
        if (hostValid) begin
          strobe.captureReq = 1'b1;
          stateD = winHit ? ST_PORT : ST_RESP;
        end
      end
      ST_PORT: begin
        portValid = 1'b1;
        if (portReady) begin
          strobe.captureRdata = 1'b1;
          stateD = ST_RESP;
        end
      end
      ST_RESP: begin
        hostRespValid = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assert_resp_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    hostRespValid |=> !hostRespValid);

  assert_port_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    portValid && !portReady |=> portValid);

  assert_resp_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostRespValid) |-> $past(hostValid && hostReady) || $past(portValid && portReady));

endmodule

// File: rtl/io_window_dp.sv
module io_window_dp
  import io_window_pkg::*;
#(
  parameter int HOST_AW   = 32,
  parameter int DATA_W    = 32,
  parameter int PORT_AW   = 16,
  parameter int SIZE_W    = 2,
  parameter int WIN_LOG2  = 23,
  parameter logic [HOST_AW-1:0] WIN_BASE = 32'h8000_0000,
  parameter int LOW_W     = 5,
  parameter int PAGE_LSB  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic               mapSparse,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrite,
  input  logic [SIZE_W-1:0]  hostSize,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic [DATA_W-1:0]  portRdata,
  output logic               winHit,
  output logic               missFlag,
  output logic [PORT_AW-1:0] portAddr,
  output logic               portWrite,
  output logic [SIZE_W-1:0]  portSize,
  output logic [DATA_W-1:0]  portWdata,
  output logic [DATA_W-1:0]  hostRdata
);

  localparam int PAGE_W = WIN_LOG2 - PAGE_LSB;
  localparam int TAG_W  = HOST_AW - WIN_LOG2;

  logic [WIN_LOG2-1:0] offset;
  logic [PORT_AW-1:0]  contigAddr, sparseAddr, foldAddr;
  logic [TAG_W-1:0]    baseTag;

  assign baseTag = WIN_BASE[HOST_AW-1:WIN_LOG2];
  assign offset  = hostAddr[WIN_LOG2-1:0];
  assign winHit  = (hostAddr[HOST_AW-1:WIN_LOG2] == baseTag);

  always_comb begin
    contigAddr = offset[PORT_AW-1:0];
    sparseAddr = '0;
    sparseAddr[LOW_W-1:0]      = offset[LOW_W-1:0];
    sparseAddr[LOW_W +: PAGE_W] = offset[WIN_LOG2-1:PAGE_LSB];
    foldAddr = mapSparse ? sparseAddr : contigAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missFlag  <= 1'b0;
      portAddr  <= '0;
      portWrite <= 1'b0;
      portSize  <= '0;
      portWdata <= '0;
      hostRdata <= '0;
    end else begin
      if (strobe.captureReq) begin
        missFlag  <= !winHit;
        portAddr  <= foldAddr;
        portWrite <= hostWrite;
        portSize  <= hostSize;
        portWdata <= hostWdata;
        hostRdata <= '0;
      end
      if (strobe.captureRdata) begin
        hostRdata <= portRdata;
      end
    end
  end

endmodule

// File: rtl/io_window_bridge.sv
module io_window_bridge
  import io_window_pkg::*;
#(
  parameter int HOST_AW  = 32,
  parameter int DATA_W   = 32,
  parameter int PORT_AW  = 16,
  parameter int SIZE_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mapSparse,
  input  logic               hostValid,
  output logic               hostReady,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrite,
  input  logic [SIZE_W-1:0]  hostSize,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic               hostRespValid,
  output logic               hostMiss,
  output logic [DATA_W-1:0]  hostRdata,
  output logic               portValid,
  input  logic               portReady,
  output logic [PORT_AW-1:0] portAddr,
  output logic               portWrite,
  output logic [SIZE_W-1:0]  portSize,
  output logic [DATA_W-1:0]  portWdata,
  input  logic [DATA_W-1:0]  portRdata
);

  dpStrobe_t strobe;
  logic      winHit;
  logic      missFlag;

  io_window_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .hostValid     (hostValid),
    .winHit        (winHit),
    .portReady     (portReady),
    .hostReady     (hostReady),
    .portValid     (portValid),
    .hostRespValid (hostRespValid),
    .strobe        (strobe)
  );

  io_window_dp #(
    .HOST_AW (HOST_AW),
    .DATA_W  (DATA_W),
    .PORT_AW (PORT_AW),
    .SIZE_W  (SIZE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mapSparse (mapSparse),
    .hostAddr  (hostAddr),
    .hostWrite (hostWrite),
    .hostSize  (hostSize),
    .hostWdata (hostWdata),
    .portRdata (portRdata),
    .winHit    (winHit),
    .missFlag  (missFlag),
    .portAddr  (portAddr),
    .portWrite (portWrite),
    .portSize  (portSize),
    .portWdata (portWdata),
    .hostRdata (hostRdata)
  );

  assign hostMiss = missFlag && hostRespValid;

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    portValid && !portReady |=> $stable(portAddr) && $stable(portSize)
                                && $stable(portWrite) && $stable(portWdata));

  assert_miss_noport_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostMiss |-> !$past(portValid));

endmodule

// File: tb/io_window_bridge_bench.sv
`timescale 1ns/1ps
module io_window_bridge_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        mapSparse;
  logic        hostValid;
  logic        hostReady;
  logic [31:0] hostAddr;
  logic        hostWrite;
  logic [1:0]  hostSize;
  logic [31:0] hostWdata;
  logic        hostRespValid;
  logic        hostMiss;
  logic [31:0] hostRdata;
  logic        portValid;
  logic        portReady;
  logic [15:0] portAddr;
  logic        portWrite;
  logic [1:0]  portSize;
  logic [31:0] portWdata;
  logic [31:0] portRdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  io_window_bridge u_io_window_bridge (
    .clk(clk), .rstN(rstN), .mapSparse(mapSparse),
    .hostValid(hostValid), .hostReady(hostReady), .hostAddr(hostAddr),
    .hostWrite(hostWrite), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostRespValid(hostRespValid), .hostMiss(hostMiss), .hostRdata(hostRdata),
    .portValid(portValid), .portReady(portReady), .portAddr(portAddr),
    .portWrite(portWrite), .portSize(portSize), .portWdata(portWdata),
    .portRdata(portRdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expAddr(input logic [31:0] a, input bit sp);
    longint off;
    longint r;
    off = longint'(a) - 64'h8000_0000;
    if (sp) r = (((off / 4096) % 2048) * 32) + (off % 32);
    else    r = off % 65536;
    return r[15:0];
  endfunction

  function automatic bit inWin(input logic [31:0] a);
    return (a >= 32'h8000_0000) && (a <= 32'h807F_FFFF);
  endfunction

  task automatic access(input logic [31:0] addr, input bit wr, input logic [1:0] sz,
                        input logic [31:0] wd, input bit sp, input int dly,
                        input bit flipMode, input logic [31:0] rd, input string req);
    logic [15:0] ea;
    ea = expAddr(addr, sp);
    @(negedge clk);
    hostValid = 1'b1; hostAddr = addr; hostWrite = wr; hostSize = sz;
    hostWdata = wd; mapSparse = sp;
    chk(hostReady == 1'b1, "R8 idle ready", {31'd0, hostReady}, 32'd1);
    @(negedge clk);
    hostValid = 1'b0;
    if (flipMode) mapSparse = ~sp;
    if (!inWin(addr)) begin
      chk(portValid == 1'b0, "R5 no port cycle", {31'd0, portValid}, 32'd0);
      chk(hostRespValid && hostMiss, "R5 miss response",
          {30'd0, hostRespValid, hostMiss}, 32'd3);
      chk(hostRdata == 32'd0, "R5 miss rdata", hostRdata, 32'd0);
      @(negedge clk);
      chk(!hostRespValid && hostReady, "R5 pulse end",
          {30'd0, hostRespValid, hostReady}, 32'd1);
      return;
    end
    chk(portValid == 1'b1, {req, " R1 hit"}, {31'd0, portValid}, 32'd1);
    chk(portAddr == ea, {req, " port address"}, {16'd0, portAddr}, {16'd0, ea});
    chk(portSize == sz && portWrite == wr && portWdata == wd, "R4 passthrough",
        {portSize, portWrite, portWdata[28:0]}, {sz, wr, wd[28:0]});
    chk(hostReady == 1'b0, "R8 busy", {31'd0, hostReady}, 32'd0);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(portValid && portAddr == ea, flipMode ? "R6 mode held" : "R7 hold",
          {15'd0, portValid, portAddr}, {15'd0, 1'b1, ea});
    end
    portReady = 1'b1; portRdata = rd;
    @(negedge clk);
    portReady = 1'b0; portRdata = 32'hDEAD_0000;
    chk(hostRespValid && !hostMiss && !portValid, "R7 response",
        {29'd0, hostRespValid, hostMiss, portValid}, 32'd4);
    if (!wr) chk(hostRdata == rd, "R7 read data", hostRdata, rd);
    @(negedge clk);
    chk(!hostRespValid && hostReady, "R7 single pulse",
        {30'd0, hostRespValid, hostReady}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; mapSparse = 1'b0; hostValid = 1'b0; hostAddr = '0;
    hostWrite = 1'b0; hostSize = '0; hostWdata = '0; portReady = 1'b0; portRdata = '0;
    repeat (3) @(negedge clk);
    chk(hostReady && !portValid && !hostRespValid, "R8 reset",
        {29'd0, hostReady, portValid, hostRespValid}, 32'd4);
    rstN = 1'b1;

    // window edges and outside neighbours
    access(32'h8000_0000, 1'b0, 2'd0, 32'h0, 1'b0, 0, 1'b0, 32'h11, "R2 low edge");
    access(32'h807F_FFFF, 1'b0, 2'd0, 32'h0, 1'b1, 0, 1'b0, 32'h22, "R3 high edge");
    access(32'h7FFF_FFFF, 1'b0, 2'd0, 32'h0, 1'b0, 0, 1'b0, 32'h0, "R5");
    access(32'h8080_0000, 1'b1, 2'd2, 32'h5, 1'b1, 0, 1'b0, 32'h0, "R5");
    access(32'h0000_0000, 1'b0, 2'd1, 32'h0, 1'b0, 0, 1'b0, 32'h0, "R5");
    access(32'hFFFF_FFFF, 1'b0, 2'd2, 32'h0, 1'b1, 0, 1'b0, 32'h0, "R5");

    // sizes and delays
    for (int s = 0; s < 3; s++) begin
      access(32'h8012_3456 + s, 1'b1, s[1:0], 32'hA5A5_0000 + s, 1'b0, s + 1, 1'b0,
             32'h0, "R4 write size");
      access(32'h8045_6789 + s, 1'b0, s[1:0], 32'h0, 1'b1, 3 - s, 1'b0,
             32'hC0DE_0000 + s, "R4 read size");
    end

    // mode change while pending
    access(32'h8034_5FE3, 1'b0, 2'd1, 32'h0, 1'b0, 3, 1'b1, 32'h77, "R6 contig");
    access(32'h8034_5FE3, 1'b0, 2'd1, 32'h0, 1'b1, 3, 1'b1, 32'h88, "R6 sparse");

    // sparse sweep over every page, middle bits varied
    for (int p = 0; p < 2048; p++) begin
      logic [31:0] a;
      a = 32'h8000_0000 + p * 4096 + ((p * 37) % 4096);
      access(a, p[0], 2'd0, p, 1'b1, p % 2, 1'b0, p * 3, "R3 sparse sweep");
    end

    // contiguous sweep
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] a;
      a = 32'h8000_0000 + ((i * 32'h0001_2345) % 32'h0080_0000);
      access(a, 1'b0, 2'd2, 32'h0, 1'b0, 0, 1'b0, i, "R2 contig sweep");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule